// File: doc/BRIEF.md
# Ping-Pong Sample Output Demultiplexer

This block is the digital output stage of a fast sampling converter. On every rising edge of the encode clock it takes one 8-bit code that has already been quantized. It then routes that code, after a fixed pipeline delay, to one of two output ports. In single-port mode every code goes to port A at the full clock rate. In dual-port mode successive codes go to port A and port B in turn, so each port refreshes at half the clock rate. A downstream register can then capture each port at the slower rate.

An internal one-bit lane phase picks the port for each code. After reset this phase comes from a seed pin, so the power-up port order is not fixed. A falling edge on the sync input pins the phase to a known state. If the phase already agrees with that state, the sync has no effect. A continuous half-rate sync pulse train is therefore harmless. If the phase disagrees, the port order slips by one code. The two codes around the slip are replaced by a filler value, one on each port. After any change of mode, a reset or a new sync is required.

The outputs are a stream without back-pressure: the converter cannot pause. `a_valid` and `b_valid` mark the cycles in which each port takes a new code, and the consumer must accept every such beat. There is no ready input. The input side has no valid strobe either, because every encode edge carries a sample.

Top module: `ping_pong_demux`

## Requirements
- R1: `mode_single` = 1 selects single-port operation, in which only port A carries data. `mode_single` = 0 selects dual-port operation on both ports.
- R2: In single-port mode, the code on `din` at encode edge k appears on `port_a` with `a_valid` = 1 just after edge k+4, and this repeats on every edge.
- R3: In single-port mode, `port_b` keeps its value and `b_valid` stays 0.
- R4: In dual-port mode, the code taken at edge k appears just after edge k+5 on the port of its lane: lane 0 is port A and lane 1 is port B. Lanes alternate, each port updates at most every other edge, and `a_valid` and `b_valid` are never 1 together.
- R5: A synchronous active-high `rst` clears `port_a`, `port_b`, `a_valid` and `b_valid` to 0. It also loads the lane phase from `seed_phase`, so the first code taken after reset uses lane `seed_phase`.
- R6: A sync fall is seen at edge e when `sync_in` was 1 at edge e-1 and is 0 at edge e. The code taken at edge e then uses lane 1 (port B), and the code taken at edge e+1 uses lane 0 (port A).
- R7: A sync fall at an edge whose phase already selects lane 1 changes no output. A sync toggling at half rate in step with the lanes leaves the data intact.
- R8: A sync fall at an edge whose phase selects lane 0 is a conflict. The codes taken at edges e and e+1 come out as `FILL_CODE` (0x80 by default), the first on port B and the second on port A. All other codes are unchanged.
- R9: Codes are straight offset binary and pass through unaltered, including 0x00, 0x80 and 0xFF.
- R10: In single-port mode, sync activity has no effect on `port_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; a sample is taken on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seed_phase | input | 1 | Lane phase loaded during reset |
| mode_single | input | 1 | 1: single-port, 0: dual-port |
| sync_in | input | 1 | Data-sync input; its falling edge aligns the lanes |
| din | input | CODE_W | Quantized sample code |
| port_a | output | CODE_W | Output port A |
| a_valid | output | 1 | Port A took a new code this cycle |
| port_b | output | CODE_W | Output port B |
| b_valid | output | 1 | Port B took a new code this cycle |

## Verification
A sync fall and a lane decision can land on the same edge. The hard case is a fall that arrives while the phase points at port A, because the sync then redirects the code being taken and marks the next one as lost. This is provoked by loading each seed and applying a single fall on an even and on an odd edge after reset, with and without a half-rate train after it. It is judged by comparing both ports on every cycle against a lane schedule worked out from the rules, expecting exactly one filler per port only in the conflicting runs.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  // per-sample tag travelling alongside the code
  typedef struct packed {
    logic vld;   // stage holds a captured sample
    logic lane;  // 0: port A, 1: port B
    logic bad;   // replaced by filler in dual-port mode
  } tag_t;
endpackage

// File: rtl/dmx_sync_edge.sv
module dmx_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic fall_o
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync_in;
  end

  // high at the previous edge, low at this one
  assign fall_o = sync_q & ~sync_in;
endmodule

// File: rtl/dmx_lane_phase.sv
module dmx_lane_phase (
  input  logic clk,
  input  logic rst,
  input  logic seed_i,
  input  logic fall_i,
  output logic lane_o,
  output logic bad_o
);
  logic phase_q;
  logic pend_q;
  logic conflict;

  // a sync forces the current sample onto lane 1
  assign lane_o   = fall_i ? 1'b1 : phase_q;
  assign conflict = fall_i & ~phase_q;
  assign bad_o    = conflict | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= seed_i;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= ~lane_o;
      pend_q  <= conflict;
    end
  end
endmodule

// File: rtl/dmx_delay_line.sv
module dmx_delay_line
  import dmx_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code_i,
  input  tag_t         tag_i,
  output logic [W-1:0] code_o [DEPTH],
  output tag_t         tag_o  [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          code_o[0] <= '0;
          tag_o[0]  <= '0;
        end else begin
          code_o[0] <= code_i;
          tag_o[0]  <= tag_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          code_o[i] <= '0;
          tag_o[i]  <= '0;
        end else begin
          code_o[i] <= code_o[i-1];
          tag_o[i]  <= tag_o[i-1];
        end
      end
    end
  end
endmodule

// File: rtl/ping_pong_demux.sv
module ping_pong_demux
  import dmx_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned LAT_SINGLE = 4,
  parameter int unsigned LAT_DUAL   = 5,
  parameter logic [CODE_W-1:0] FILL_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_phase,
  input  logic              mode_single,
  input  logic              sync_in,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] port_a,
  output logic              a_valid,
  output logic [CODE_W-1:0] port_b,
  output logic              b_valid
);
  // the output register adds one edge beyond the tap
  localparam int unsigned DEPTH  = LAT_DUAL;
  localparam int unsigned TAP_SP = LAT_SINGLE - 1;
  localparam int unsigned TAP_DP = LAT_DUAL - 1;

  logic              fall;
  logic              lane;
  logic              bad;
  tag_t              in_tag;
  logic [CODE_W-1:0] st_code [DEPTH];
  tag_t              st_tag  [DEPTH];
  logic [CODE_W-1:0] sel_code;
  tag_t              sel_tag;
  logic [CODE_W-1:0] dual_code;

  dmx_sync_edge u_sync (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_in),
    .fall_o  (fall)
  );

  dmx_lane_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .seed_i (seed_phase),
    .fall_i (fall),
    .lane_o (lane),
    .bad_o  (bad)
  );

  assign in_tag = '{vld: 1'b1, lane: lane, bad: bad};

  dmx_delay_line #(
    .W     (CODE_W),
    .DEPTH (DEPTH)
  ) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .code_i (din),
    .tag_i  (in_tag),
    .code_o (st_code),
    .tag_o  (st_tag)
  );

  always_comb begin
    if (mode_single) begin
      sel_code = st_code[TAP_SP];
      sel_tag  = st_tag[TAP_SP];
    end else begin
      sel_code = st_code[TAP_DP];
      sel_tag  = st_tag[TAP_DP];
    end
  end

  assign dual_code = sel_tag.bad ? FILL_CODE : sel_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_a  <= '0;
      port_b  <= '0;
      a_valid <= 1'b0;
      b_valid <= 1'b0;
    end else begin
      a_valid <= 1'b0;
      b_valid <= 1'b0;
      if (sel_tag.vld) begin
        if (mode_single) begin
          port_a  <= sel_code;
          a_valid <= 1'b1;
        end else if (!sel_tag.lane) begin
          port_a  <= dual_code;
          a_valid <= 1'b1;
        end else begin
          port_b  <= dual_code;
          b_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dmx_checker.sv
module dmx_checker #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_single,
  input logic [CODE_W-1:0] port_b,
  input logic              a_valid,
  input logic              b_valid
);
  assert_ports_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_valid, b_valid}));

  assert_single_b_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    mode_single |=> (!b_valid && $stable(port_b)));

  assert_a_no_repeat_R4: assert property (@(posedge clk) disable iff (rst)
    (!mode_single && $past(!mode_single) && a_valid) |=> (mode_single || !a_valid));

  assert_single_stream_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_single && $past(mode_single) && a_valid) |=> (!mode_single || a_valid));
endmodule

bind ping_pong_demux dmx_checker #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_single (mode_single),
  .port_b      (port_b),
  .a_valid     (a_valid),
  .b_valid     (b_valid)
);

// File: tb/ping_pong_demux_tb.sv
`timescale 1ns/1ps
module ping_pong_demux_tb;
  localparam logic [7:0] FILL = 8'h80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seed_phase = 1'b0;
  logic       mode_single = 1'b0;
  logic       sync_in = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] port_a, port_b;
  logic       a_valid, b_valid;

  ping_pong_demux u_dut (
    .clk (clk), .rst (rst), .seed_phase (seed_phase),
    .mode_single (mode_single), .sync_in (sync_in), .din (din),
    .port_a (port_a), .a_valid (a_valid), .port_b (port_b), .b_valid (b_valid)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit m_ph, m_sq, m_cp;
  logic [7:0] exp_a, exp_b;
  bit         lane_m [0:1023];
  bit         bad_m  [0:1023];
  logic [7:0] code_m [0:1023];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %0d expected %0d", req, what, n, act, exp);
    end
  endtask

  task automatic do_reset(input bit seed_v, input bit mode_v);
    @(negedge clk);
    rst = 1'b1; seed_phase = seed_v; mode_single = mode_v; sync_in = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    check(port_a == 8'h00, "R5", "port_a after reset", port_a, 0);
    check(port_b == 8'h00, "R5", "port_b after reset", port_b, 0);
    check(!a_valid && !b_valid, "R5", "valids after reset", {a_valid, b_valid}, 0);
    rst = 1'b0;
    n = 0; m_ph = seed_v; m_sq = 1'b0; m_cp = 1'b0;
    exp_a = '0; exp_b = '0;
  endtask

  task automatic step(input logic [7:0] code, input bit s, input string req);
    bit fall, conf, ea, eb;
    int j;
    string r;
    logic [7:0] v;
    din = code; sync_in = s;
    n++;
    // lane schedule from the sync rules
    fall = m_sq & ~s;
    lane_m[n] = fall ? 1'b1 : m_ph;
    conf = fall & ~m_ph;
    bad_m[n] = conf | m_cp;
    code_m[n] = code;
    m_ph = ~lane_m[n]; m_cp = conf; m_sq = s;
    @(posedge clk);
    @(negedge clk);
    j = n - (mode_single ? 4 : 5);
    ea = 1'b0; eb = 1'b0; r = req;
    if (j >= 1) begin
      if (mode_single) begin
        ea = 1'b1; exp_a = code_m[j];
      end else begin
        v = bad_m[j] ? FILL : code_m[j];
        if (bad_m[j]) r = "R8";
        if (!lane_m[j]) begin ea = 1'b1; exp_a = v; end
        else begin eb = 1'b1; exp_b = v; end
      end
    end
    check(port_a == exp_a, r, "port_a", port_a, exp_a);
    check(a_valid == ea, r, "a_valid", a_valid, ea);
    check(port_b == exp_b, mode_single ? "R3" : r, "port_b", port_b, exp_b);
    check(b_valid == eb, mode_single ? "R3" : r, "b_valid", b_valid, eb);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired at edge %0d: actual 1 expected 0", n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // dual-port, both seeds, no sync (R1, R4, R5)
    do_reset(1'b0, 1'b0);
    for (int k = 1; k <= 40; k++) step(8'((k * 37 + 11) & 255), 1'b0, "R4/R5/R1");
    do_reset(1'b1, 1'b0);
    for (int k = 1; k <= 40; k++) step(8'((k * 53 + 7) & 255), 1'b0, "R4/R5");

    // sync in step with the phase, then a half-rate train (R6, R7)
    do_reset(1'b0, 1'b0);
    for (int k = 1; k <= 60; k++)
      step(8'((k * 29 + 3) & 255), (k >= 19) ? bit'((k - 20) & 1) : 1'b0, "R6/R7");

    // same train against the other phase: one conflict (R6, R8)
    do_reset(1'b1, 1'b0);
    for (int k = 1; k <= 60; k++)
      step(8'((k * 29 + 3) & 255), (k >= 19) ? bit'((k - 20) & 1) : 1'b0, "R6/R8");

    // lone conflicting fall, sync left low afterwards (R8)
    do_reset(1'b0, 1'b0);
    for (int k = 1; k <= 40; k++) step(8'((k * 71 + 5) & 255), k == 10, "R8/R6");

    // single-port sweep of all codes with sync toggling (R1, R2, R3, R9, R10)
    do_reset(1'b1, 1'b1);
    for (int k = 1; k <= 270; k++) step(8'((k - 1) & 255), bit'(k & 1), "R2/R9/R10/R1");

    // dual-port sweep of all codes after an aligned sync (R4, R9)
    do_reset(1'b0, 1'b0);
    for (int k = 1; k <= 270; k++) step(8'((k - 1) & 255), k == 9, "R4/R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule